// File: doc/BRIEF.md
# Lockable Address Translation Cache

This block is a small, fully associative cache of address translations. Software manages it through plain register strobes. It stages a tag word and a data word, then commits them with a load strobe into the slot that a victim pointer names. The block also offers a per-address invalidate, an invalidate of the whole array, and a read-back port that always shows the slot under the victim pointer. A combinational lookup port takes a 32-bit device virtual address. In the same cycle it returns hit and miss flags, the translated physical address and four attribute bits.

Software can pin slots at the low end of the array. Each pinned load goes to the slot at the lock base and then moves the base up. When the victim pointer runs off the top of the array it returns to the base, not to slot 0, so normal replacement never reaches the pinned slots. Each slot maps one of four page sizes, and the page size decides how many address bits take part in the compare.

Top module: `xlat_cache`

## Requirements
- R1: The ENTRIES parameter must be 8 or 32 (default 32). Base and victim fields are FW = log2(ENTRIES)+1 bits wide: 6 bits for 32 entries, 4 bits for 8.
- R2: `lock_rdata` shows the lock base at bit 10 upward and the victim pointer at bit 4 upward, each FW bits wide, with all other bits zero. A `lock_we` strobe loads both fields from the same positions of `lock_wdata`.
- R3: `cam_we` and `ram_we` stage the tag word and the data word. The staged tag word always has bit 2 (valid) set. A `load_strobe` copies both staged words into the target slot one clock later.
- R4: After an accepted load the victim pointer is the target index plus one. If that value equals ENTRIES, the pointer takes the (updated) base value instead.
- R5: If tag bit 3 (pin) is set, the load targets the slot at the base and the base then increments. If the target index (base for a pinned load, victim for a normal load) equals or exceeds ENTRIES, the load is refused: no slot or pointer changes and `load_busy` is 1 from the next cycle. An accepted load clears `load_busy`.
- R6: `rd_cam` and `rd_ram` show the slot selected by the victim pointer, or zero when the pointer is ENTRIES or more.
- R7: `flush_all` clears the valid bit of every slot and sets base, victim and `load_busy` to 0. It takes priority over a load or a lock write in the same cycle.
- R8: Tag bits 1:0 set the page size: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB. A slot matches when it is valid and its tag equals the address on every bit above the page offset.
- R9: `flush_one` clears the valid bit of the lowest-index valid slot whose page contains `flush_va` and leaves every other slot untouched.
- R10: On a hit, `lk_pa` takes the data-word bits above the page offset and the `lk_va` bits below it. `lk_attr` is data-word bits 9:6 (endianness at 9, element size at 8:7, mixed at 6).
- R11: When several slots match, the lowest index wins. With no match, `lk_miss` is 1, `lk_hit` is 0, and `lk_pa` and `lk_attr` are 0.
- R12: After a synchronous active-low reset, every slot holds zero, base and victim are 0 and `load_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_we | input | 1 | Write strobe for the lock base and victim fields |
| lock_wdata | input | 32 | Lock write value |
| lock_rdata | output | 32 | Current lock base and victim fields |
| cam_we | input | 1 | Stage a tag word |
| cam_wdata | input | 32 | Tag word: page tag, pin bit 3, page size 1:0 |
| ram_we | input | 1 | Stage a data word |
| ram_wdata | input | 32 | Data word: physical page and attributes |
| load_strobe | input | 1 | Commit the staged words |
| load_busy | output | 1 | Last load was refused |
| flush_one | input | 1 | Invalidate the slot covering flush_va |
| flush_va | input | 32 | Address for the single invalidate |
| flush_all | input | 1 | Invalidate all slots and clear the pointers |
| rd_cam | output | 32 | Tag word of the slot under the victim pointer |
| rd_ram | output | 32 | Data word of the slot under the victim pointer |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 4 | Attribute bits of the hit slot |

## Verification
The lookup outputs are combinational over the slot registers, so the bench reads them a fixed delay after it drives `lk_va` on a falling edge. Strobed operations (staging, load, lock write and both flushes) land on the next rising edge. Their effects on `lock_rdata`, `rd_cam`/`rd_ram`, `load_busy` and later lookups are therefore sampled at the falling edge one clock after the strobe. A staged word needs two edges before the load strobe can commit it, and every task keeps to that spacing.

// File: rtl/xlat_pkg.sv
// xlat_pkg: shared field positions, page-size encoding and tag masks for
// the address translation cache. Assumes 32-bit addresses and a 4 KB minimum page.
package xlat_pkg;
    localparam int WORD_W   = 32;
    localparam int VALID_B  = 2;   // tag word: slot valid
    localparam int PIN_B    = 3;   // tag word: pinned load request
    localparam int BASE_LSB = 10;  // lock word: base field start
    localparam int VICT_LSB = 4;   // lock word: victim field start
    localparam int ATTR_LSB = 6;   // data word: attribute field start
    localparam int ATTR_W   = 4;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    // Tag mask for a page size: ones on the bits that take part in the compare.
    function automatic logic [WORD_W-1:0] tag_mask(input logic [1:0] sz);
        case (pg_size_e'(sz))
            PG_4K:   tag_mask = 32'hFFFF_F000;
            PG_64K:  tag_mask = 32'hFFFF_0000;
            PG_1M:   tag_mask = 32'hFFF0_0000;
            default: tag_mask = 32'hFF00_0000;
        endcase
    endfunction
endpackage

// File: rtl/xlat_first_hit.sv
// xlat_first_hit: picks the lowest set bit of a match vector.
// Assumes N >= 2. The index is zero when nothing is set.
module xlat_first_hit #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  match,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest index is the one left standing.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_lock_ctrl.sv
// xlat_lock_ctrl: holds the lock base and victim pointer, picks the slot
// for each load, decides whether the load is accepted, and keeps the busy flag.
// Assumes flush_all takes priority over a load, and a load over a lock write.
module xlat_lock_ctrl #(
    parameter int N  = 32,
    parameter int IW = $clog2(N),
    parameter int FW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_we,
    input  logic [FW-1:0] base_wd,
    input  logic [FW-1:0] vict_wd,
    input  logic          load_req,
    input  logic          load_pin,
    input  logic          flush_all,
    output logic [FW-1:0] base_q,
    output logic [FW-1:0] vict_q,
    output logic [IW-1:0] tgt_idx,
    output logic          load_ok,
    output logic          busy_q
);
    localparam logic [FW-1:0] LIMIT = FW'(N);

    logic [FW-1:0] tgt, base_nx, vict_nx;

    // Target slot and the pointer values after an accepted load.
    always_comb begin
        tgt     = load_pin ? base_q : vict_q;
        base_nx = load_pin ? base_q + 1'b1 : base_q;
        vict_nx = tgt + 1'b1;
        if (vict_nx == LIMIT) vict_nx = base_nx;
    end

    assign tgt_idx = tgt[IW-1:0];
    assign load_ok = load_req && !flush_all && (tgt < LIMIT);

    // Pointer and busy state update, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            vict_q <= '0;
            busy_q <= 1'b0;
        end else if (flush_all) begin
            base_q <= '0;
            vict_q <= '0;
            busy_q <= 1'b0;
        end else if (load_req) begin
            if (tgt < LIMIT) begin
                base_q <= base_nx;
                vict_q <= vict_nx;
                busy_q <= 1'b0;
            end else begin
                busy_q <= 1'b1;
            end
        end else if (lock_we) begin
            base_q <= base_wd;
            vict_q <= vict_wd;
        end
    end
endmodule

// File: rtl/xlat_slot_array.sv
// xlat_slot_array: staging words plus N tag/data slot pairs, with the
// per-slot compares for the lookup and the single-invalidate addresses.
// Assumes load_go and flush_hit are already qualified by the caller.
module xlat_slot_array
    import xlat_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cam_we,
    input  logic [WORD_W-1:0]      cam_wdata,
    input  logic                   ram_we,
    input  logic [WORD_W-1:0]      ram_wdata,
    input  logic                   load_go,
    input  logic [IW-1:0]          load_idx,
    input  logic                   flush_all,
    input  logic                   flush_hit,
    input  logic [IW-1:0]          flush_idx,
    input  logic [WORD_W-1:0]      lk_va,
    input  logic [WORD_W-1:0]      fl_va,
    output logic                   stg_pin,
    output logic [N-1:0]           lk_match,
    output logic [N-1:0]           fl_match,
    output logic [N-1:0][WORD_W-1:0] cam_arr,
    output logic [N-1:0][WORD_W-1:0] ram_arr
);
    logic [WORD_W-1:0] stg_cam, stg_ram;

    // Staging registers; the staged tag word always carries the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_cam <= '0;
            stg_ram <= '0;
        end else begin
            if (cam_we) stg_cam <= cam_wdata | (WORD_W'(1) << VALID_B);
            if (ram_we) stg_ram <= ram_wdata;
        end
    end

    assign stg_pin = stg_cam[PIN_B];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [WORD_W-1:0] cam_q, ram_q;

        // Slot update: invalidate-all, then load, then single invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cam_q <= '0;
                ram_q <= '0;
            end else if (flush_all) begin
                cam_q[VALID_B] <= 1'b0;
            end else if (load_go && load_idx == IW'(g)) begin
                cam_q <= stg_cam;
                ram_q <= stg_ram;
            end else if (flush_hit && flush_idx == IW'(g)) begin
                cam_q[VALID_B] <= 1'b0;
            end
        end

        assign cam_arr[g]  = cam_q;
        assign ram_arr[g]  = ram_q;
        assign lk_match[g] = cam_q[VALID_B] &&
                             (((cam_q ^ lk_va) & tag_mask(cam_q[1:0])) == '0);
        assign fl_match[g] = cam_q[VALID_B] &&
                             (((cam_q ^ fl_va) & tag_mask(cam_q[1:0])) == '0);
    end
endmodule

// File: rtl/xlat_cache.sv
// xlat_cache: lockable fully associative translation cache, top level.
// Joins the lock control, the slot array and two lowest-index selectors,
// then forms the lookup result and the read-back words.
// Assumes ENTRIES is 8 or 32; the lookup path is purely combinational.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_we,
    input  logic [31:0] lock_wdata,
    output logic [31:0] lock_rdata,
    input  logic        cam_we,
    input  logic [31:0] cam_wdata,
    input  logic        ram_we,
    input  logic [31:0] ram_wdata,
    input  logic        load_strobe,
    output logic        load_busy,
    input  logic        flush_one,
    input  logic [31:0] flush_va,
    input  logic        flush_all,
    output logic [31:0] rd_cam,
    output logic [31:0] rd_ram,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic [31:0] lk_pa,
    output logic [3:0]  lk_attr
);
    localparam int IW = $clog2(ENTRIES);
    localparam int FW = IW + 1;
    localparam logic [31:0] FIELD_ONES = (32'd1 << FW) - 1;
    localparam logic [31:0] LOCK_USED  = (FIELD_ONES << BASE_LSB) | (FIELD_ONES << VICT_LSB);

    logic [FW-1:0] base_q, vict_q;
    logic [IW-1:0] tgt_idx, lk_idx, fl_idx;
    logic          load_ok, stg_pin, lk_found, fl_found;
    logic [ENTRIES-1:0] lk_match, fl_match;
    logic [ENTRIES-1:0][31:0] cam_arr, ram_arr;
    logic [31:0]   hit_cam, hit_ram, hit_mask;
    logic          unused_lockbits;

    assign unused_lockbits = ^(lock_wdata & ~LOCK_USED);

    xlat_lock_ctrl #(.N(ENTRIES), .IW(IW), .FW(FW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_we  (lock_we),
        .base_wd  (lock_wdata[BASE_LSB +: FW]),
        .vict_wd  (lock_wdata[VICT_LSB +: FW]),
        .load_req (load_strobe),
        .load_pin (stg_pin),
        .flush_all(flush_all),
        .base_q   (base_q),
        .vict_q   (vict_q),
        .tgt_idx  (tgt_idx),
        .load_ok  (load_ok),
        .busy_q   (load_busy)
    );

    xlat_slot_array #(.N(ENTRIES), .IW(IW)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .cam_we   (cam_we),
        .cam_wdata(cam_wdata),
        .ram_we   (ram_we),
        .ram_wdata(ram_wdata),
        .load_go  (load_ok),
        .load_idx (tgt_idx),
        .flush_all(flush_all),
        .flush_hit(flush_one && fl_found),
        .flush_idx(fl_idx),
        .lk_va    (lk_va),
        .fl_va    (flush_va),
        .stg_pin  (stg_pin),
        .lk_match (lk_match),
        .fl_match (fl_match),
        .cam_arr  (cam_arr),
        .ram_arr  (ram_arr)
    );

    xlat_first_hit #(.N(ENTRIES), .IW(IW)) u_lk_pick (
        .match(lk_match), .found(lk_found), .idx(lk_idx)
    );

    xlat_first_hit #(.N(ENTRIES), .IW(IW)) u_fl_pick (
        .match(fl_match), .found(fl_found), .idx(fl_idx)
    );

    // Lookup result: page bits from the data word, offset bits from the address.
    always_comb begin
        hit_cam  = cam_arr[lk_idx];
        hit_ram  = ram_arr[lk_idx];
        hit_mask = tag_mask(hit_cam[1:0]);
        lk_hit   = lk_found;
        lk_miss  = !lk_found;
        lk_pa    = lk_found ? ((hit_ram & hit_mask) | (lk_va & ~hit_mask)) : '0;
        lk_attr  = lk_found ? hit_ram[ATTR_LSB +: ATTR_W] : '0;
    end

    // Lock word and victim read-back.
    always_comb begin
        lock_rdata = '0;
        lock_rdata[BASE_LSB +: FW] = base_q;
        lock_rdata[VICT_LSB +: FW] = vict_q;
        rd_cam = (vict_q < FW'(ENTRIES)) ? cam_arr[vict_q[IW-1:0]] : '0;
        rd_ram = (vict_q < FW'(ENTRIES)) ? ram_arr[vict_q[IW-1:0]] : '0;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
// xlat_cache_chk: port-level properties of xlat_cache, attached by bind.
// Assumes the same ENTRIES value as the design it is bound to.
module xlat_cache_chk #(
    parameter int ENTRIES = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_all,
    input logic        load_strobe,
    input logic        stg_pin,
    input logic [31:0] lock_rdata,
    input logic        load_busy,
    input logic        lk_hit,
    input logic [31:0] lk_va,
    input logic [31:0] lk_pa
);
    localparam int FW = $clog2(ENTRIES) + 1;

    // Build-time entry count must be one of the two supported sizes.
    initial begin
        assert_entries_legal_R1: assert (ENTRIES == 8 || ENTRIES == 32);
    end

    // A global invalidate leaves the pointers at zero and nothing hitting.
    assert_flush_all_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (lock_rdata == 32'd0) && !lk_hit);

    // A pinned load with the base at the top is refused and moves nothing.
    assert_pin_full_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && !flush_all && stg_pin && lock_rdata[10 +: FW] == FW'(ENTRIES))
        |=> load_busy && $stable(lock_rdata));

    // Busy only ever rises right after a load strobe.
    assert_busy_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_busy) |-> $past(load_strobe));

    // The 4 KB offset always passes straight through on a hit.
    assert_offset_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_all  (flush_all),
    .load_strobe(load_strobe),
    .stg_pin    (stg_pin),
    .lock_rdata (lock_rdata),
    .load_busy  (load_busy),
    .lk_hit     (lk_hit),
    .lk_va      (lk_va),
    .lk_pa      (lk_pa)
);

// File: tb/xlat_cache_bench.sv
// xlat_cache_bench: near-exhaustive sweep of an 8-slot cache against a
// behavioural model kept in the bench.
module xlat_cache_bench;
    localparam int BN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_we = 1'b0, cam_we = 1'b0, ram_we = 1'b0;
    logic        load_strobe = 1'b0, flush_one = 1'b0, flush_all = 1'b0;
    logic [31:0] lock_wdata = '0, cam_wdata = '0, ram_wdata = '0;
    logic [31:0] flush_va = '0, lk_va = '0;
    logic [31:0] lock_rdata, rd_cam, rd_ram, lk_pa;
    logic        load_busy, lk_hit, lk_miss;
    logic [3:0]  lk_attr;

    int nchk = 0, nfail = 0;
    logic [31:0] mcam [BN];
    logic [31:0] mram [BN];
    int mbase = 0, mvict = 0;
    logic mbusy = 1'b0;

    always #4 clk = ~clk;

    xlat_cache #(.ENTRIES(BN)) u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_wdata(lock_wdata),
        .lock_rdata(lock_rdata), .cam_we(cam_we), .cam_wdata(cam_wdata),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .load_strobe(load_strobe),
        .load_busy(load_busy), .flush_one(flush_one), .flush_va(flush_va),
        .flush_all(flush_all), .rd_cam(rd_cam), .rd_ram(rd_ram), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_attr(lk_attr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lock_word();
        return (32'(mbase) << 10) | (32'(mvict) << 4);
    endfunction

    task automatic check_lock(input string req);
        check(req, lock_rdata, lock_word());
        check(req, {31'd0, load_busy}, {31'd0, mbusy});
    endtask

    task automatic load(input logic [31:0] c, input logic [31:0] r);
        int tgt;
        @(negedge clk); cam_we = 1; cam_wdata = c; ram_we = 1; ram_wdata = r;
        @(negedge clk); cam_we = 0; ram_we = 0; load_strobe = 1;
        @(negedge clk); load_strobe = 0;
        tgt = c[3] ? mbase : mvict;
        if (tgt >= BN) mbusy = 1'b1;
        else begin
            mcam[tgt] = c | 32'h4;
            mram[tgt] = r;
            mbusy = 1'b0;
            if (c[3]) mbase = tgt + 1;
            mvict = tgt + 1;
            if (mvict == BN) mvict = mbase;
        end
    endtask

    task automatic wr_lock(input int b, input int v);
        @(negedge clk); lock_we = 1; lock_wdata = (32'(b) << 10) | (32'(v) << 4) | 32'hFFFF_C30F;
        @(negedge clk); lock_we = 0;
        mbase = b; mvict = v;
    endtask

    task automatic do_flush_all();
        @(negedge clk); flush_all = 1;
        @(negedge clk); flush_all = 0;
        for (int i = 0; i < BN; i++) mcam[i][2] = 1'b0;
        mbase = 0; mvict = 0; mbusy = 1'b0;
    endtask

    task automatic do_flush_one(input logic [31:0] a);
        logic done;
        @(negedge clk); flush_one = 1; flush_va = a;
        @(negedge clk); flush_one = 0;
        done = 1'b0;
        for (int i = 0; i < BN; i++) begin
            logic [31:0] m;
            m = 32'hFFFF_FFFF << (12 + 4 * int'(mcam[i][1:0]));
            if (!done && mcam[i][2] && ((mcam[i] ^ a) & m) == 0) begin
                mcam[i][2] = 1'b0;
                done = 1'b1;
            end
        end
    endtask

    task automatic look(input string req, input logic [31:0] va);
        logic hit;
        logic [31:0] pa;
        logic [3:0] at;
        lk_va = va;
        #1;
        hit = 1'b0; pa = '0; at = '0;
        for (int i = BN - 1; i >= 0; i--) begin
            logic [31:0] m;
            m = 32'hFFFF_FFFF << (12 + 4 * int'(mcam[i][1:0]));
            if (mcam[i][2] && ((mcam[i] ^ va) & m) == 0) begin
                hit = 1'b1;
                pa = (mram[i] & m) | (va & ~m);
                at = mram[i][9:6];
            end
        end
        check(req, {31'd0, lk_hit}, {31'd0, hit});
        check(req, {31'd0, lk_miss}, {31'd0, !hit});
        check(req, lk_pa, pa);
        check(req, {28'd0, lk_attr}, {28'd0, at});
    endtask

    task automatic readback(input string req, input int k);
        wr_lock(mbase, k);
        check(req, rd_cam, (k < BN) ? mcam[k] : 32'd0);
        check(req, rd_ram, (k < BN) ? mram[k] : 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < BN; i++) begin mcam[i] = '0; mram[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        check_lock("R12");
        check("R12", rd_cam, 32'd0);
        check("R12", rd_ram, 32'd0);
        look("R12", 32'h0000_0000);

        // R2: both lock fields written and read at their positions
        wr_lock(3, 5);
        check("R2", lock_rdata, 32'h0000_0C50);
        // R7: global flush clears pointers
        do_flush_all();
        check_lock("R7");

        // R1 R3 R4: fill all slots with each page size
        for (int i = 0; i < BN; i++) begin
            load((32'(i + 1) << 24) | 32'(i % 4),
                 32'h8000_0000 | (32'(i) << 24) | 32'h00AB_C000 | (32'(i % 16) << 6));
            check_lock("R4");
        end
        check("R1", lock_rdata, 32'h0);

        // R6 R3: read-back of every slot
        for (int k = 0; k < BN; k++) readback("R6", k);
        readback("R6", BN);

        // R8 R10: lookup sweep at page edges
        for (int k = 0; k < BN; k++) begin
            logic [31:0] base_va, sz;
            base_va = 32'(k + 1) << 24;
            sz = 32'd1 << (12 + 4 * (k % 4));
            look("R8", base_va);
            look("R10", base_va | 32'h0000_0ABC);
            look("R8", base_va + sz - 1);
            look("R8", base_va + sz);
            look("R8", base_va ^ 32'h8000_0000);
        end

        // R11: overlapping pages, lowest index wins
        do_flush_all();
        load(32'h1000_0003, 32'h2000_0040);
        load(32'h1000_3000, 32'h3000_5380);
        look("R11", 32'h1000_3ABC);
        look("R11", 32'h1000_4ABC);
        look("R11", 32'h2000_0000);
        // R9: single invalidate hits only the winning slot
        do_flush_one(32'h1000_3ABC);
        look("R9", 32'h1000_3ABC);
        look("R9", 32'h1000_4ABC);
        do_flush_one(32'h5555_0000);
        look("R9", 32'h1000_3ABC);
        readback("R9", 0);
        readback("R9", 1);

        // R5 R4: pinned region and wrap to base
        do_flush_all();
        for (int j = 0; j < 3; j++) load(32'h4000_0008 + (32'(j) << 12), 32'h6000_0000 + (32'(j) << 12));
        check_lock("R5");
        for (int j = 0; j < 6; j++) begin
            load(32'h5000_0000 + (32'(j) << 12), 32'h7000_0000 + (32'(j) << 12));
            check_lock("R4");
        end
        for (int j = 0; j < 3; j++) look("R5", 32'h4000_0123 + (32'(j) << 12));
        look("R4", 32'h5000_0123);
        look("R4", 32'h5000_5123);
        for (int j = 0; j < 5; j++) begin
            load(32'h4800_0008 + (32'(j) << 12), 32'h6800_0000 + (32'(j) << 12));
            check_lock("R5");
        end
        load(32'h4900_0008, 32'h6900_0000);
        check_lock("R5");
        look("R5", 32'h4900_0000);
        load(32'h4A00_0000, 32'h6A00_0000);
        check_lock("R5");
        do_flush_all();
        check_lock("R7");
        look("R7", 32'h4000_0123);
        load(32'h4B00_0000, 32'h6B00_0000);
        check_lock("R5");
        look("R3", 32'h4B00_0FFF);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule